// File: doc/BRIEF.md
# Modified Berger Check Symbol Encoder

This block encodes an information word into a code that detects unidirectional errors. It produces a two-part check symbol. The first part counts the zero bits of the word and reduces that count modulo `MAX_WEIGHT + 1`, where `MAX_WEIGHT` is the largest unidirectional error weight the code must catch. The second part counts the zero bits of the first part and writes that count in binary. This makes the second part shorter than a bitwise complement of the first part would be.

The word width and the error weight are parameters. Two implementations of the modulo step are provided. When `MAX_WEIGHT + 1` is a power of two, the step keeps the low bits of the count. Otherwise it performs a true division remainder. An optional output register is selected by a parameter. The encoder is used on operands entering a checked datapath. It is also used at the output of a logic unit, where it builds the actual symbol that is compared against a predicted one.

Top module: `mberger_encoder`

## Requirements
- R1: The first check part is `ceil(log2(MAX_WEIGHT+1))` bits wide, and the second is `ceil(log2(w1+1))` bits wide, where w1 is the width of the first part. The codeword is `DATA_W + w1 + w2` bits wide. The defaults (`DATA_W`=32, `MAX_WEIGHT`=7) give 3, 2 and 37.
- R2: `ck1_out` equals the number of zero bits in the word, modulo `MAX_WEIGHT+1`, as an unsigned binary value. Examples: 32 zeros give 000, 31 zeros give 111, 30 zeros give 110, and 1 zero gives 001.
- R3: `ck2_out` equals, in unsigned binary, the number of zero bits inside `ck1_out`. Examples: 000 gives 11, 111 gives 00, 110 gives 01, and 001 gives 10.
- R4: `code_out` is the word in bits [DATA_W+w1+w2-1 : w1+w2], then `ck1_out` in bits [w1+w2-1 : w2], then `ck2_out` in bits [w2-1 : 0].
- R5: With `REG_OUT`=1, all outputs reflect the word present at the previous rising clock edge. They hold that value between edges.
- R6: With `REG_OUT`=1, a synchronous active-high `rst` makes all outputs zero after the edge at which it is sampled. Data presented during reset is not captured.
- R7: When `MAX_WEIGHT+1` is not a power of two, the reduction is a true remainder. For example, with `MAX_WEIGHT`=5, 32 zeros give 010 and 31 zeros give 001.
- R8: With `REG_OUT`=0, the outputs follow `data_in` in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| data_in | input | DATA_W | Information word to encode |
| ck1_out | output | w1 | Zero count modulo MAX_WEIGHT+1 |
| ck2_out | output | w2 | Zero count of ck1_out |
| code_out | output | DATA_W+w1+w2 | Word followed by both check parts |

## Verification
The only state in this block is the optional output register. Every other fault lives in the adder tree, the reduction or the second-part counter. A broken tree node or a wrong reduction shows up as a wrong `ck1_out` one edge after a word that drives that node away from zero. A wrong second-part count shows up in `ck2_out` in that same cycle. A register that fails to load, or fails to clear, is visible at the very next edge. Corner words are applied directly: all zeros, all ones, a single one, two ones, and a single zero at the top. Random words are applied as well, so that every leaf of the tree is toggled.

// File: rtl/mbcode_pkg.sv
package mbcode_pkg;

    localparam int DEF_DATA_W     = 32;
    localparam int DEF_MAX_WEIGHT = 7;

    typedef enum logic [0:0] {
        RED_SLICE  = 1'b0,
        RED_DIVIDE = 1'b1
    } red_kind_e;

    function automatic int ck1_width(input int max_weight);
        return $clog2(max_weight + 1);
    endfunction

    function automatic int ck2_width(input int w1);
        return $clog2(w1 + 1);
    endfunction

    function automatic int count_width(input int n);
        return $clog2(n + 1);
    endfunction

    function automatic red_kind_e pick_reduction(input int max_weight);
        int modv;
        modv = max_weight + 1;
        return ((modv & (modv - 1)) == 0) ? RED_SLICE : RED_DIVIDE;
    endfunction

endpackage

// File: rtl/mbc_zero_count.sv
module mbc_zero_count #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 6
) (
    input  logic [DATA_W-1:0] data_in,
    output logic [CNT_W-1:0]  zeros
);
    localparam int LEAVES = 1 << $clog2(DATA_W);

    logic [CNT_W-1:0] node [1:2*LEAVES-1];

    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
        if (i < DATA_W) begin : g_real
            assign node[LEAVES+i] = data_in[i] ? '0 : CNT_W'(1);
        end else begin : g_pad
            assign node[LEAVES+i] = '0;
        end
    end

    for (genvar k = 1; k < LEAVES; k++) begin : g_sum
        assign node[k] = node[2*k] + node[2*k+1];
    end

    assign zeros = node[1];
endmodule

// File: rtl/mbc_mod_reduce.sv
module mbc_mod_reduce
    import mbcode_pkg::*;
#(
    parameter int CNT_W      = 6,
    parameter int MAX_WEIGHT = 7,
    parameter int CK1_W      = 3
) (
    input  logic [CNT_W-1:0] zeros,
    output logic [CK1_W-1:0] ck1
);
    localparam red_kind_e KIND = pick_reduction(MAX_WEIGHT);

    if (KIND == RED_SLICE) begin : g_slice
        assign ck1 = CK1_W'(zeros & CNT_W'(MAX_WEIGHT));
    end else begin : g_divide
        assign ck1 = CK1_W'(zeros % CNT_W'(MAX_WEIGHT + 1));
    end
endmodule

// File: rtl/mbc_ck2_gen.sv
module mbc_ck2_gen #(
    parameter int CK1_W = 3,
    parameter int CK2_W = 2
) (
    input  logic [CK1_W-1:0] ck1,
    output logic [CK2_W-1:0] ck2
);
    always_comb begin
        ck2 = '0;
        for (int i = 0; i < CK1_W; i++) begin
            ck2 = ck2 + (ck1[i] ? '0 : CK2_W'(1));
        end
    end
endmodule

// File: rtl/mberger_encoder.sv
module mberger_encoder
    import mbcode_pkg::*;
#(
    parameter int DATA_W     = DEF_DATA_W,
    parameter int MAX_WEIGHT = DEF_MAX_WEIGHT,
    parameter bit REG_OUT    = 1'b1,
    localparam int CNT_W  = count_width(DATA_W),
    localparam int CK1_W  = ck1_width(MAX_WEIGHT),
    localparam int CK2_W  = ck2_width(CK1_W),
    localparam int CODE_W = DATA_W + CK1_W + CK2_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] data_in,
    output logic [CK1_W-1:0]  ck1_out,
    output logic [CK2_W-1:0]  ck2_out,
    output logic [CODE_W-1:0] code_out
);
    logic [CNT_W-1:0] zero_cnt;
    logic [CK1_W-1:0] ck1_c;
    logic [CK2_W-1:0] ck2_c;
    logic [CODE_W-1:0] code_c;

    mbc_zero_count #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_zero_count (
        .data_in (data_in),
        .zeros   (zero_cnt)
    );

    mbc_mod_reduce #(.CNT_W(CNT_W), .MAX_WEIGHT(MAX_WEIGHT), .CK1_W(CK1_W)) u_mod_reduce (
        .zeros (zero_cnt),
        .ck1   (ck1_c)
    );

    mbc_ck2_gen #(.CK1_W(CK1_W), .CK2_W(CK2_W)) u_ck2_gen (
        .ck1 (ck1_c),
        .ck2 (ck2_c)
    );

    assign code_c = {data_in, ck1_c, ck2_c};

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                ck1_out  <= '0;
                ck2_out  <= '0;
                code_out <= '0;
            end else begin
                ck1_out  <= ck1_c;
                ck2_out  <= ck2_c;
                code_out <= code_c;
            end
        end
    end else begin : g_comb
        assign ck1_out  = ck1_c;
        assign ck2_out  = ck2_c;
        assign code_out = code_c;
    end
endmodule

// File: rtl/mberger_encoder_chk.sv
module mberger_encoder_chk
    import mbcode_pkg::*;
#(
    parameter int DATA_W     = DEF_DATA_W,
    parameter int MAX_WEIGHT = DEF_MAX_WEIGHT,
    parameter bit REG_OUT    = 1'b1,
    localparam int CK1_W  = ck1_width(MAX_WEIGHT),
    localparam int CK2_W  = ck2_width(CK1_W),
    localparam int CODE_W = DATA_W + CK1_W + CK2_W
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] data_in,
    input logic [CK1_W-1:0]  ck1_out,
    input logic [CK2_W-1:0]  ck2_out,
    input logic [CODE_W-1:0] code_out
);
    if (REG_OUT) begin : g_reg
        // R2 R5
        ck1_value_chk: assert property (@(posedge clk) disable iff (rst)
            !rst |=> ck1_out == CK1_W'((DATA_W - $countones($past(data_in))) % (MAX_WEIGHT + 1)));

        // R3
        ck2_value_chk: assert property (@(posedge clk) disable iff (rst)
            !rst |=> ck2_out == CK2_W'(CK1_W - $countones(ck1_out)));

        // R4
        data_field_chk: assert property (@(posedge clk) disable iff (rst)
            !rst |=> code_out[CODE_W-1 -: DATA_W] == $past(data_in));

        // R2
        ck1_range_chk: assert property (@(posedge clk) disable iff (rst)
            !rst |=> ck1_out <= CK1_W'(MAX_WEIGHT));

        // R6
        reset_clear_chk: assert property (@(posedge clk)
            rst |=> (code_out == '0) && (ck1_out == '0) && (ck2_out == '0));
    end else begin : g_comb
        // R7 R8
        ck1_now_chk: assert property (@(posedge clk) disable iff (rst)
            ck1_out == CK1_W'((DATA_W - $countones(data_in)) % (MAX_WEIGHT + 1)));

        // R3
        ck2_now_chk: assert property (@(posedge clk) disable iff (rst)
            ck2_out == CK2_W'(CK1_W - $countones(ck1_out)));

        // R4
        data_now_chk: assert property (@(posedge clk) disable iff (rst)
            code_out[CODE_W-1 -: DATA_W] == data_in);
    end
endmodule

bind mberger_encoder mberger_encoder_chk #(
    .DATA_W(DATA_W), .MAX_WEIGHT(MAX_WEIGHT), .REG_OUT(REG_OUT)
) u_chk (
    .clk(clk), .rst(rst), .data_in(data_in),
    .ck1_out(ck1_out), .ck2_out(ck2_out), .code_out(code_out)
);

// File: tb/mberger_encoder_bench.sv
`timescale 1ns/1ps
module mberger_encoder_bench;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [DW-1:0] stim = '0;

    logic [2:0]  a_ck1, b_ck1;
    logic [1:0]  a_ck2, b_ck2;
    logic [36:0] a_code, b_code;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    mberger_encoder #(.DATA_W(32), .MAX_WEIGHT(7), .REG_OUT(1'b1)) u_mberger_encoder (
        .clk(clk), .rst(rst), .data_in(stim),
        .ck1_out(a_ck1), .ck2_out(a_ck2), .code_out(a_code)
    );

    mberger_encoder #(.DATA_W(32), .MAX_WEIGHT(5), .REG_OUT(1'b0)) u_mberger_encoder_m5 (
        .clk(clk), .rst(rst), .data_in(stim),
        .ck1_out(b_ck1), .ck2_out(b_ck2), .code_out(b_code)
    );

    localparam logic [31:0] TBL_DATA [0:8] = '{
        32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0003, 32'h7FFF_FFFF,
        32'hC503_F3A1, 32'h7ACA_5F53, 32'h4002_5301, 32'hFFCB_FFF3
    };
    localparam logic [2:0] TBL_CK1 [0:8] = '{3'd0, 3'd0, 3'd7, 3'd6, 3'd1, 3'd1, 3'd5, 3'd1, 3'd5};
    localparam logic [1:0] TBL_CK2 [0:8] = '{2'd3, 2'd3, 2'd0, 2'd1, 2'd2, 2'd2, 2'd1, 2'd2, 2'd1};

    function automatic int zeros_of(input logic [31:0] d);
        int z = 0;
        for (int i = 0; i < 32; i++) if (d[i] == 1'b0) z++;
        return z;
    endfunction

    function automatic logic [2:0] model_ck1(input logic [31:0] d, input int m);
        return 3'(zeros_of(d) % (m + 1));
    endfunction

    function automatic logic [1:0] model_ck2(input logic [2:0] c);
        int z = 0;
        for (int i = 0; i < 3; i++) if (c[i] == 1'b0) z++;
        return 2'(z);
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    task automatic check_reg(input logic [31:0] d, input string req);
        logic [2:0] e1;
        logic [1:0] e2;
        e1 = model_ck1(d, 7);
        e2 = model_ck2(e1);
        chk(req, "ck1", 64'(a_ck1), 64'(e1));
        chk("R3", "ck2", 64'(a_ck2), 64'(e2));
        chk("R4", "code", 64'(a_code), 64'({d, e1, e2}));
    endtask

    task automatic check_m5(input logic [31:0] d);
        logic [2:0] e1;
        e1 = model_ck1(d, 5);
        chk("R7", "m5 ck1", 64'(b_ck1), 64'(e1));
        chk("R8", "m5 code", 64'(b_code), 64'({d, e1, model_ck2(e1)}));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] prev;
        logic [31:0] r;

        // R1: widths
        chk("R1", "ck1 width", 64'($bits(a_ck1)), 64'd3);
        chk("R1", "ck2 width", 64'($bits(a_ck2)), 64'd2);
        chk("R1", "code width", 64'($bits(a_code)), 64'd37);

        // R6: reset clears outputs, data during reset not captured
        repeat (3) @(posedge clk);
        @(negedge clk) stim = 32'h0000_0001;
        @(posedge clk);
        #1;
        chk("R6", "code in reset", 64'(a_code), 64'd0);
        chk("R6", "ck1 in reset", 64'(a_ck1), 64'd0);
        chk("R6", "ck2 in reset", 64'(a_ck2), 64'd0);
        @(negedge clk) rst = 1'b0;
        stim = 32'h0;

        // Table walk: R2 R3 R4 R5 corner words, plus R7 R8 on comb instance
        prev = 32'hx;
        for (int i = 0; i < 9; i++) begin
            @(negedge clk) stim = TBL_DATA[i];
            #1;
            check_m5(TBL_DATA[i]);
            if (i > 0) begin
                // R5: registered outputs still hold the previous word
                chk("R5", "hold before edge", 64'(a_code), 64'({prev, TBL_CK1[i-1], TBL_CK2[i-1]}));
            end
            @(posedge clk);
            #1;
            chk("R2", "table ck1", 64'(a_ck1), 64'(TBL_CK1[i]));
            chk("R3", "table ck2", 64'(a_ck2), 64'(TBL_CK2[i]));
            chk("R4", "table code", 64'(a_code), 64'({TBL_DATA[i], TBL_CK1[i], TBL_CK2[i]}));
            prev = TBL_DATA[i];
        end

        // R7: direct non-power-of-two values
        @(negedge clk) stim = 32'h0;
        #1;
        chk("R7", "m5 32 zeros", 64'(b_ck1), 64'd2);
        chk("R7", "m5 ck2 of 010", 64'(b_ck2), 64'd2);
        stim = 32'h0000_0001;
        #1;
        chk("R7", "m5 31 zeros", 64'(b_ck1), 64'd1);

        // Random words: R2 on both instances
        for (int n = 0; n < 300; n++) begin
            @(negedge clk);
            r = $urandom();
            if (n % 4 == 1) r = r & $urandom();
            if (n % 4 == 2) r = r | $urandom();
            stim = r;
            #1;
            check_m5(r);
            @(posedge clk);
            #1;
            check_reg(r, "R2");
        end

        // R6: mid-run reset
        @(negedge clk) begin
            stim = 32'h1234_5678;
            rst = 1'b1;
        end
        @(posedge clk);
        #1;
        chk("R6", "mid-run reset code", 64'(a_code), 64'd0);
        @(negedge clk) rst = 1'b0;
        @(posedge clk);
        #1;
        check_reg(32'h1234_5678, "R6");

        finish_run();
    end
endmodule